// File: doc/BRIEF.md
# Seedable Pseudo-Random Shift Register

This block is a Fibonacci-style linear feedback shift register whose serial input comes from a two-way selector. One leg of the selector carries an external serial seed bit. The other leg carries the feedback term, which is built from two tap bits of the register.

With the seed leg selected, the register is a plain shift register. Any starting value can be shifted in, one bit per enabled clock. With the feedback leg selected, the register steps through its maximal-length sequence, starting from whatever it holds at that moment.

A synchronous reset forces a fixed nonzero seed. Each flop resets to its own constant bit, so the register never starts in the lock-up state. A parameter picks XOR or XNOR feedback. The lock-up state is all-zeros for XOR and all-ones for XNOR.

Top module: `lfsr_seedable`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, `lfsrState` becomes `RST_SEED` on that edge, whatever `stepEn`, `loadMode` and `seedIn` are. The default `RST_SEED` is `4'b0001`, which is the lock-up state for neither polarity.
- R2: With `rst` low and `stepEn` low, `lfsrState` keeps its value across the edge.
- R3: With `rst` low, `stepEn` high and `loadMode` high, the next state is `{lfsrState[WIDTH-2:0], seedIn}`. Bit 0 takes `seedIn` and the other bits move one place toward the MSB. Four such edges therefore load any 4-bit value, MSB first. The seed path takes priority over the feedback.
- R4: With `rst` low, `stepEn` high and `loadMode` low, and with XOR feedback (`USE_XNOR`=0), the next state is `{lfsrState[WIDTH-2:0], lfsrState[TAP_A] ^ lfsrState[TAP_B]}`. For width 4 the taps are bits 3 and 2.
- R5: With width 4, taps 3 and 2, and either polarity, run mode started from any state other than the lock-up state returns to that state after exactly 15 steps and not sooner.
- R6: With XOR feedback, all-zeros is a lock-up state: run steps from `4'b0000` leave the register at `4'b0000`.
- R7: With XNOR feedback (`USE_XNOR`=1), the run-mode feedback bit is the inverse of the XOR of the two tap bits. All-ones (`4'b1111`) is then the lock-up state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset; loads the hard-wired seed |
| stepEn | input | 1 | Enables one shift on this edge |
| loadMode | input | 1 | 1 = shift `seedIn` in, 0 = feedback step |
| seedIn | input | 1 | Serial seed bit |
| lfsrState | output | WIDTH | Parallel register contents |

## Verification
The bench loads every 4-bit value through the seed path, for both polarities, and checks each load shift. This exposes a reversed shift direction or a swapped selector, either of which would leave a different seed in the register. From every non-lock-up seed it then runs 15 feedback steps against an arithmetic model and checks that the start state returns at exactly step 15. A wrong tap or a wrong polarity would shorten the period or change the walk. It also parks the register in each lock-up state and applies reset while `stepEn` is low and `loadMode` is high. A design with the wrong priority would drift out of lock-up or ignore the reset.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic clear;     // force the hard-wired seed
    logic shift;     // advance the register this edge
    logic takeSeed;  // serial input comes from seedIn
  } lfsrStrobe_t;
endpackage

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
  import lfsr_pkg::*;
(
  input  logic        rst,
  input  logic        stepEn,
  input  logic        loadMode,
  output lfsrStrobe_t strobe
);
  // Priority: reset, then load, then feedback step
  always_comb begin
    strobe.clear    = rst;
    strobe.shift    = stepEn & ~rst;
    strobe.takeSeed = loadMode;
  end
endmodule

// File: rtl/lfsr_dp.sv
module lfsr_dp
  import lfsr_pkg::*;
#(
  parameter int              WIDTH    = 4,
  parameter int              TAP_A    = 3,
  parameter int              TAP_B    = 2,
  parameter bit              USE_XNOR = 1'b0,
  parameter logic [WIDTH-1:0] RST_SEED = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rst,
  input  lfsrStrobe_t      strobe,
  input  logic             seedIn,
  output logic [WIDTH-1:0] state
);
  localparam logic [WIDTH-1:0] LOCKUP = USE_XNOR ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic             fbBit;
  logic             serialIn;
  logic [WIDTH-1:0] nextVec;

  generate
    if (USE_XNOR) begin : g_xnor
      assign fbBit = ~(state[TAP_A] ^ state[TAP_B]);
    end else begin : g_xor
      assign fbBit = state[TAP_A] ^ state[TAP_B];
    end
  endgenerate

  // Input selector: seed leg or feedback leg
  assign serialIn = strobe.takeSeed ? seedIn : fbBit;
  assign nextVec  = {state[WIDTH-2:0], serialIn};

  // One flop per bit, each clearing or setting to its own seed bit
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (strobe.clear)      state[i] <= RST_SEED[i];
        else if (strobe.shift) state[i] <= nextVec[i];
      end
    end
  endgenerate

  // R1: reset loads the seed regardless of the other inputs
  p_reset_seed_r1: assert property (@(posedge clk) rst |=> (state == RST_SEED))
    else $error("reset seed not loaded");

  // R2: no enable, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !strobe.shift |=> $stable(state))
    else $error("state moved without enable");

  // R3: load mode behaves as a plain shift register
  p_load_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.shift && strobe.takeSeed) |=>
      (state == {$past(state[WIDTH-2:0]), $past(seedIn)}))
    else $error("load shift wrong");

  // R4/R7: run step shifts upward and inserts the tap combination
  p_run_step_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.shift && !strobe.takeSeed) |=>
      ((state[WIDTH-1:1] == $past(state[WIDTH-2:0])) &&
       (state[0] == ($past(state[TAP_A] ^ state[TAP_B]) ^ USE_XNOR))))
    else $error("run step wrong");

  // R6/R7: the lock-up state is never left in run mode
  p_lockup_stays_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe.shift && !strobe.takeSeed && state == LOCKUP) |=> (state == LOCKUP))
    else $error("left lock-up state");
endmodule

// File: rtl/lfsr_seedable.sv
module lfsr_seedable
  import lfsr_pkg::*;
#(
  parameter int              WIDTH    = 4,
  parameter int              TAP_A    = 3,
  parameter int              TAP_B    = 2,
  parameter bit              USE_XNOR = 1'b0,
  parameter logic [WIDTH-1:0] RST_SEED = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stepEn,
  input  logic             loadMode,
  input  logic             seedIn,
  output logic [WIDTH-1:0] lfsrState
);
  lfsrStrobe_t strobe;

  lfsr_ctrl u_ctrl (
    .rst      (rst),
    .stepEn   (stepEn),
    .loadMode (loadMode),
    .strobe   (strobe)
  );

  lfsr_dp #(
    .WIDTH    (WIDTH),
    .TAP_A    (TAP_A),
    .TAP_B    (TAP_B),
    .USE_XNOR (USE_XNOR),
    .RST_SEED (RST_SEED)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .seedIn (seedIn),
    .state  (lfsrState)
  );
endmodule

// File: tb/lfsr_seedable_tb.sv
module lfsr_seedable_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stepEn = 1'b0;
  logic       loadMode = 1'b0;
  logic       seedIn = 1'b0;
  logic [3:0] stX;
  logic [3:0] stN;
  logic [3:0] expX;
  logic [3:0] expN;
  int         nChecks = 0;
  int         nFails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lfsr_seedable #(.USE_XNOR(1'b0)) u_dut (
    .clk(clk), .rst(rst), .stepEn(stepEn), .loadMode(loadMode),
    .seedIn(seedIn), .lfsrState(stX));

  lfsr_seedable #(.USE_XNOR(1'b1)) u_dut_xnor (
    .clk(clk), .rst(rst), .stepEn(stepEn), .loadMode(loadMode),
    .seedIn(seedIn), .lfsrState(stN));

  function automatic logic [3:0] runNext(logic [3:0] s, logic inv);
    return {s[2:0], s[3] ^ s[2] ^ inv};
  endfunction

  task automatic check(logic [3:0] act, logic [3:0] exp, string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // Drive at negedge, sample 1 ns after the following posedge
  task automatic cycle(logic r, logic en, logic ld, logic sd);
    @(negedge clk);
    rst = r; stepEn = en; loadMode = ld; seedIn = sd;
    @(posedge clk);
    #1;
    if (r) begin
      expX = 4'b0001; expN = 4'b0001;
    end else if (en) begin
      expX = ld ? {expX[2:0], sd} : runNext(expX, 1'b0);
      expN = ld ? {expN[2:0], sd} : runNext(expN, 1'b1);
    end
  endtask

  task automatic loadSeed(logic [3:0] v, string req);
    for (int b = 3; b >= 0; b--) begin
      cycle(1'b0, 1'b1, 1'b1, v[b]);
      check(stX, expX, req);
      check(stN, expN, req);
    end
    check(stX, v, req);
    check(stN, v, req);
  endtask

  initial begin
    expX = 4'b0001; expN = 4'b0001;
    cycle(1'b1, 1'b0, 1'b0, 1'b0);
    cycle(1'b1, 1'b0, 1'b0, 1'b0);
    check(stX, 4'b0001, "R1");
    check(stN, 4'b0001, "R1");

    // R2: hold with enable low, load and seed toggled
    for (int k = 0; k < 4; k++) begin
      cycle(1'b0, 1'b0, k[0], k[1]);
      check(stX, 4'b0001, "R2");
      check(stN, 4'b0001, "R2");
    end

    // R4 / R7 single steps from the reset seed
    cycle(1'b0, 1'b1, 1'b0, 1'b0);
    check(stX, 4'b0010, "R4");
    check(stN, 4'b0011, "R7");

    // R3 / R5: every seed through the load path, then a full period
    for (int s = 0; s < 16; s++) begin
      logic [3:0] start;
      start = s[3:0];
      loadSeed(start, "R3");
      for (int n = 1; n <= 15; n++) begin
        cycle(1'b0, 1'b1, 1'b0, 1'b0);
        check(stX, expX, "R4");
        check(stN, expN, "R7");
        if (start != 4'b0000) begin
          nChecks++;
          if ((stX == start) != (n == 15)) begin
            nFails++;
            $display("FAIL R5: xor seed %b step %0d got %b expected %s",
                     start, n, stX, (n == 15) ? "return" : "no return");
          end
        end
        if (start != 4'b1111) begin
          nChecks++;
          if ((stN == start) != (n == 15)) begin
            nFails++;
            $display("FAIL R5: xnor seed %b step %0d got %b expected %s",
                     start, n, stN, (n == 15) ? "return" : "no return");
          end
        end
      end
    end

    // R6 / R7: lock-up states persist
    loadSeed(4'b0000, "R6");
    for (int k = 0; k < 5; k++) begin
      cycle(1'b0, 1'b1, 1'b0, 1'b0);
      check(stX, 4'b0000, "R6");
    end
    loadSeed(4'b1111, "R7");
    for (int k = 0; k < 5; k++) begin
      cycle(1'b0, 1'b1, 1'b0, 1'b0);
      check(stN, 4'b1111, "R7");
    end

    // R1: reset wins over load and enable
    loadSeed(4'b1010, "R3");
    cycle(1'b1, 1'b1, 1'b1, 1'b1);
    check(stX, 4'b0001, "R1");
    check(stN, 4'b0001, "R1");
    loadSeed(4'b0110, "R3");
    cycle(1'b1, 1'b0, 1'b1, 1'b0);
    check(stX, 4'b0001, "R1");
    check(stN, 4'b0001, "R1");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule